// File: doc/BRIEF.md
# Serial Configuration Load Sequencer

This block brings up a programmable device through its slave-serial configuration pins. It drives an active-low program line, a configuration clock and a serial data line. It watches the device's init and done inputs. After a start pulse it runs a reset handshake in two steps. First it pulls program low and waits for init to fall. Then it releases program and waits for init to rise again.

Once the handshake is complete, the block takes one bit at a time from an upstream bit source over a valid/ready handshake. It shifts each bit out on a rising edge of the configuration clock. After the bit tagged as last, it waits for done to rise.

Each of the three waits has its own timeout, counted in pulses of an external millisecond tick. Each timeout has its own error code. The outcome is held in a 2-bit status field until the next accepted start. The upstream source is responsible for unpacking bytes, with the most significant bit sent first, and for any decompression.

Top module: `cfg_serial_loader`

## Requirements
- R1: Out of reset, progN, cfgClk and cfgData are all 1, busy is 0, bitReady is 0 and status is 0.
- R2: A start pulse accepted while idle drives progN low and busy high one cycle later, with cfgClk and cfgData still high, and clears status to 0.
- R3: While progN is low, a low level on initIn releases progN high. A later high level on initIn moves cfgClk low and begins streaming.
- R4: If initIn stays high for TIMEOUT_TICKS msTick pulses while progN is low, the block ends with status 1, busy 0 and progN, cfgClk and cfgData all high.
- R5: If initIn does not return high within TIMEOUT_TICKS msTick pulses after progN is released, the block ends with status 2 and all three lines high.
- R6: Each bit is placed on cfgData while cfgClk is low and stays there through the rising edge. From the second high cycle onward, cfgData is 1 while cfgClk remains high.
- R7: During streaming, every cfgClk high phase lasts CLK_HALF cycles. When the source has a bit ready at once, every low phase also lasts CLK_HALF cycles.
- R8: bitReady is asserted only while cfgClk is low during streaming, and exactly one bit is taken per clock period. When bitValid is low, the clock is held low until a bit arrives.
- R9: Bits appear on successive cfgClk rising edges in the order the source supplied them.
- R10: After the bit flagged by bitLast, cfgClk stays high. When doneIn goes high, the block ends with status 0 and busy 0.
- R11: If doneIn does not rise within TIMEOUT_TICKS msTick pulses after the last bit, the block ends with status 3.
- R12: status keeps its value while idle, whatever initIn, doneIn and msTick do, until the next accepted start.
- R13: A start pulse while busy is ignored: progN is not pulled low again and the transfer completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | One-cycle request to begin a configuration load |
| msTick | input | 1 | One-cycle pulse per millisecond used for timeouts |
| bitValid | input | 1 | Upstream bit available |
| bitData | input | 1 | Upstream bit value |
| bitLast | input | 1 | Marks the final bit of the stream |
| bitReady | output | 1 | Block accepts a bit this cycle |
| initIn | input | 1 | Device init line |
| doneIn | input | 1 | Device done line |
| progN | output | 1 | Active-low program line to the device |
| cfgClk | output | 1 | Configuration clock |
| cfgData | output | 1 | Configuration serial data |
| busy | output | 1 | A load is in progress |
| status | output | 2 | 0 success, 1 init-low timeout, 2 init-high timeout, 3 done timeout |

## Verification
The bench models the device's init and done lines so that each of the three waits can be made to time out. An off-by-one tick counter would show up as a mismatch in the number of msTick pulses seen while program is low, or as the wrong error code. Stalled bit sources test that ready never rises with the clock high and that no bit is dropped or repeated. A design that consumed bits on the wrong phase would produce a captured stream that differs from the pattern sent. A second start issued in mid-stream would, in a faulty design, pull program low again, and the bench flags any such fall. Status is left idle under toggling inputs after an error to catch a register that is not held.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG_LOW,
    ST_INIT_HIGH,
    ST_LOW_WAIT,
    ST_LOW_HOLD,
    ST_CLK_HIGH,
    ST_WAIT_DONE
  } ldState_e;

  localparam logic [1:0] CODE_OK        = 2'd0;
  localparam logic [1:0] CODE_INIT_LOW  = 2'd1;
  localparam logic [1:0] CODE_INIT_HIGH = 2'd2;
  localparam logic [1:0] CODE_DONE      = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic       progLow;
    logic       progRelease;
    logic       clkLow;
    logic       clkHigh;
    logic       takeBit;
    logic       dataHigh;
    logic       phaseClr;
    logic       tickClr;
    logic       statusClr;
    logic       statusLoad;
    logic [1:0] statusCode;
  } ldStrobe_t;

endpackage

// File: rtl/cfg_load_ctrl.sv
module cfg_load_ctrl
  import cfg_load_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      bitValid,
  input  logic      initIn,
  input  logic      doneIn,
  input  logic      holdDone,
  input  logic      highDone,
  input  logic      tickExpire,
  input  logic      lastHold,
  output ldStrobe_t strobe,
  output logic      busy,
  output logic      bitReady
);

  ldState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strobe.progLow   = 1'b1;
          strobe.tickClr   = 1'b1;
          strobe.statusClr = 1'b1;
          stateNext        = ST_PROG_LOW;
        end
      end
      ST_PROG_LOW: begin
        if (!initIn) begin
          strobe.progRelease = 1'b1;
          strobe.tickClr     = 1'b1;
          stateNext          = ST_INIT_HIGH;
        end else if (tickExpire) begin
          strobe.statusLoad  = 1'b1;
          strobe.statusCode  = CODE_INIT_LOW;
          strobe.progRelease = 1'b1;
          strobe.clkHigh     = 1'b1;
          strobe.dataHigh    = 1'b1;
          stateNext          = ST_IDLE;
        end
      end
      ST_INIT_HIGH: begin
        if (initIn) begin
          strobe.clkLow = 1'b1;
          stateNext     = ST_LOW_WAIT;
        end else if (tickExpire) begin
          strobe.statusLoad  = 1'b1;
          strobe.statusCode  = CODE_INIT_HIGH;
          strobe.progRelease = 1'b1;
          strobe.clkHigh     = 1'b1;
          strobe.dataHigh    = 1'b1;
          stateNext          = ST_IDLE;
        end
      end
      ST_LOW_WAIT: begin
        if (bitValid) begin
          strobe.takeBit  = 1'b1;
          strobe.phaseClr = 1'b1;
          stateNext       = ST_LOW_HOLD;
        end
      end
      ST_LOW_HOLD: begin
        if (holdDone) begin
          strobe.clkHigh  = 1'b1;
          strobe.phaseClr = 1'b1;
          stateNext       = ST_CLK_HIGH;
        end
      end
      ST_CLK_HIGH: begin
        strobe.dataHigh = 1'b1;
        if (highDone) begin
          if (lastHold) begin
            strobe.tickClr = 1'b1;
            stateNext      = ST_WAIT_DONE;
          end else begin
            strobe.clkLow = 1'b1;
            stateNext     = ST_LOW_WAIT;
          end
        end
      end
      ST_WAIT_DONE: begin
        if (doneIn) begin
          strobe.statusLoad = 1'b1;
          strobe.statusCode = CODE_OK;
          stateNext         = ST_IDLE;
        end else if (tickExpire) begin
          strobe.statusLoad = 1'b1;
          strobe.statusCode = CODE_DONE;
          strobe.clkHigh    = 1'b1;
          strobe.dataHigh   = 1'b1;
          stateNext         = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign bitReady = (state == ST_LOW_WAIT);

endmodule

// File: rtl/cfg_load_dpath.sv
module cfg_load_dpath
  import cfg_load_pkg::*;
#(
  parameter int unsigned CLK_HALF      = 3,
  parameter int unsigned TIMEOUT_TICKS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  ldStrobe_t  strobe,
  input  logic       msTick,
  input  logic       bitData,
  input  logic       bitLast,
  output logic       holdDone,
  output logic       highDone,
  output logic       tickExpire,
  output logic       lastHold,
  output logic       progN,
  output logic       cfgClk,
  output logic       cfgData,
  output logic [1:0] status
);

  localparam int unsigned PH_W   = $clog2(CLK_HALF + 1);
  localparam int unsigned TICK_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [PH_W-1:0]   HOLD_LAST = PH_W'(CLK_HALF - 2);
  localparam logic [PH_W-1:0]   HIGH_LAST = PH_W'(CLK_HALF - 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TIMEOUT_TICKS - 1);

  logic [PH_W-1:0]   phaseCnt;
  logic [TICK_W-1:0] tickCnt;

  // pin registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progN    <= 1'b1;
      cfgClk   <= 1'b1;
      cfgData  <= 1'b1;
      lastHold <= 1'b0;
    end else begin
      if (strobe.progLow)          progN <= 1'b0;
      else if (strobe.progRelease) progN <= 1'b1;
      if (strobe.clkLow)       cfgClk <= 1'b0;
      else if (strobe.clkHigh) cfgClk <= 1'b1;
      if (strobe.takeBit) begin
        cfgData  <= bitData;
        lastHold <= bitLast;
      end else if (strobe.dataHigh) begin
        cfgData <= 1'b1;
      end
    end
  end

  // phase counter for the configuration clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phaseCnt <= '0;
    else if (strobe.phaseClr) phaseCnt <= '0;
    else                      phaseCnt <= phaseCnt + 1'b1;
  end

  assign holdDone = (phaseCnt == HOLD_LAST);
  assign highDone = (phaseCnt == HIGH_LAST);

  // millisecond tick counter for the handshake timeouts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               tickCnt <= '0;
    else if (strobe.tickClr) tickCnt <= '0;
    else if (msTick)         tickCnt <= tickCnt + 1'b1;
  end

  assign tickExpire = msTick && (tickCnt == TICK_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  status <= CODE_OK;
    else if (strobe.statusClr)  status <= CODE_OK;
    else if (strobe.statusLoad) status <= strobe.statusCode;
  end

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_load_pkg::*;
#(
  parameter int unsigned CLK_HALF      = 3,
  parameter int unsigned TIMEOUT_TICKS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       msTick,
  input  logic       bitValid,
  input  logic       bitData,
  input  logic       bitLast,
  output logic       bitReady,
  input  logic       initIn,
  input  logic       doneIn,
  output logic       progN,
  output logic       cfgClk,
  output logic       cfgData,
  output logic       busy,
  output logic [1:0] status
);

  ldStrobe_t strobe;
  logic holdDone, highDone, tickExpire, lastHold;

  cfg_load_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .bitValid   (bitValid),
    .initIn     (initIn),
    .doneIn     (doneIn),
    .holdDone   (holdDone),
    .highDone   (highDone),
    .tickExpire (tickExpire),
    .lastHold   (lastHold),
    .strobe     (strobe),
    .busy       (busy),
    .bitReady   (bitReady)
  );

  cfg_load_dpath #(
    .CLK_HALF      (CLK_HALF),
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .msTick     (msTick),
    .bitData    (bitData),
    .bitLast    (bitLast),
    .holdDone   (holdDone),
    .highDone   (highDone),
    .tickExpire (tickExpire),
    .lastHold   (lastHold),
    .progN      (progN),
    .cfgClk     (cfgClk),
    .cfgData    (cfgData),
    .status     (status)
  );

endmodule

// File: rtl/cfg_load_checker.sv
module cfg_load_checker (
  input logic       clk,
  input logic       rstN,
  input logic       startPulse,
  input logic       progN,
  input logic       cfgClk,
  input logic       cfgData,
  input logic       bitReady,
  input logic       busy,
  input logic [1:0] status
);

  a_r8_ready_clk_low: assert property (@(posedge clk) disable iff (!rstN)
    bitReady |-> (!cfgClk && busy));

  a_r6_data_high_late: assert property (@(posedge clk) disable iff (!rstN)
    (cfgClk && $past(cfgClk)) |-> cfgData);

  a_r6_data_stable_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgClk) && busy |-> (cfgData == $past(cfgData)));

  a_r2_start_accept: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !busy) |=> (!progN && busy && status == 2'd0));

  a_r13_no_reprogram: assert property (@(posedge clk) disable iff (!rstN)
    $fell(progN) |-> !$past(busy));

  a_r12_status_held: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> $stable(status));

  a_r2_status_zero_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (status == 2'd0));

endmodule

bind cfg_serial_loader cfg_load_checker chk_i (.*);

// File: tb/cfg_serial_loader_tb_top.sv
module cfg_serial_loader_tb_top;

  localparam int CLK_HALF = 3;
  localparam int TIMEOUT  = 3;
  localparam int NVEC     = 8;

  typedef struct packed {
    logic [4:0]  nBits;
    logic [15:0] pattern;
    logic        dropOk;
    logic        riseOk;
    logic        doneOk;
    logic        stall;
    logic        restart;
    logic [1:0]  expStatus;
  } vec_t;

  // nBits, pattern, dropOk, riseOk, doneOk, stall, restart, expStatus
  localparam vec_t VECS [NVEC] = '{
    '{5'd8,  16'h00A5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0},
    '{5'd1,  16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0},
    '{5'd16, 16'hFF00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0},
    '{5'd12, 16'h05A3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0},
    '{5'd8,  16'h0011, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1},
    '{5'd8,  16'h0022, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2},
    '{5'd8,  16'h003C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3},
    '{5'd16, 16'h8001, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic msTick = 1'b0;
  logic bitValid = 1'b0;
  logic bitData = 1'b0;
  logic bitLast = 1'b0;
  logic initIn = 1'b1;
  logic doneIn = 1'b0;
  logic bitReady, progN, cfgClk, cfgData, busy;
  logic [1:0] status;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  cfg_serial_loader #(.CLK_HALF(CLK_HALF), .TIMEOUT_TICKS(TIMEOUT)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .msTick(msTick),
    .bitValid(bitValid), .bitData(bitData), .bitLast(bitLast),
    .bitReady(bitReady), .initIn(initIn), .doneIn(doneIn),
    .progN(progN), .cfgClk(cfgClk), .cfgData(cfgData),
    .busy(busy), .status(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic run_vec(input vec_t v, input int id);
    int nb = int'(v.nBits);
    int sent = 0;
    bit pend = 0;
    logic [15:0] cap = '0;
    int capN = 0;
    bit prevClk = 1'b1;
    bit inBit = 1'b0;
    int hiRun = 0, loRun = 0;
    int badPhase = 0, badReady = 0, badData = 0, badRestart = 0;
    int progTicks = 0;
    bit released = 0, restarted = 0, finished = 0;
    int mState = 0, mCnt = 0, dCnt = 0;
    logic [15:0] expPat;
    initIn = 1'b1; doneIn = 1'b0; bitValid = 1'b0; msTick = 1'b0;
    @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk(!progN && busy && cfgClk && cfgData && status == 2'd0, "R2 start", {progN, busy}, 1);
    for (int c = 0; c < 3000; c++) begin
      if (!busy) begin finished = 1; break; end
      // observe
      if (cfgClk && !prevClk) begin
        cap = {cap[14:0], cfgData}; capN++;
        if (!v.stall && loRun != CLK_HALF) badPhase++;
        inBit = 1; hiRun = 0;
      end
      if (cfgClk) hiRun++;
      if (!cfgClk) begin
        if (prevClk && inBit && hiRun != CLK_HALF) badPhase++;
        if (prevClk) loRun = 0;
        loRun++;
      end
      if (cfgClk && prevClk && inBit && !cfgData) badData++;
      if (bitReady && cfgClk) badReady++;
      if (progN && !released && mState == 1) released = 1;
      if (!progN && released) badRestart++;
      // bit source
      sent += int'(pend);
      bitValid = (sent < nb) && !(v.stall && (c % 3) != 0);
      bitData  = (sent < nb) ? v.pattern[nb - 1 - sent] : 1'b0;
      bitLast  = (sent == nb - 1);
      pend     = bitReady && bitValid;
      // device model
      case (mState)
        0: if (!progN) begin mState = 1; mCnt = 0; end
        1: begin
          if (v.dropOk) begin mCnt++; if (mCnt == 4) initIn = 1'b0; end
          if (progN) begin mState = 2; mCnt = 0; end
        end
        default: if (v.riseOk && !initIn) begin mCnt++; if (mCnt == 4) initIn = 1'b1; end
      endcase
      if (v.doneOk && sent == nb && cfgClk) dCnt++;
      if (dCnt == 6) doneIn = 1'b1;
      msTick = ((c % 16) == 15);
      if (msTick && !progN) progTicks++;
      startPulse = v.restart && !restarted && (sent == nb / 2) && capN > 0;
      if (startPulse) restarted = 1;
      prevClk = cfgClk;
      @(negedge clk);
    end
    msTick = 1'b0; bitValid = 1'b0; startPulse = 1'b0;
    expPat = v.pattern & 16'((32'd1 << nb) - 1);
    chk(finished == 1, "R10 end reached", int'(finished), 1);
    case (v.expStatus)
      2'd1: chk(status == 2'd1, "R4 init-low timeout code", status, 1);
      2'd2: chk(status == 2'd2, "R5 init-high timeout code", status, 2);
      2'd3: chk(status == 2'd3, "R11 done timeout code", status, 3);
      default: chk(status == 2'd0, "R10 success code", status, 0);
    endcase
    if (v.expStatus == 2'd0 || v.expStatus == 2'd3) begin
      chk(capN == nb, "R9 bit count", capN, nb);
      chk(cap == expPat, "R9 bit order", cap, expPat);
      chk(badPhase == 0, "R7 clock phase lengths", badPhase, 0);
      chk(badData == 0, "R6 data high after first high cycle", badData, 0);
      chk(badReady == 0, "R8 ready only with clock low", badReady, 0);
    end
    if (v.expStatus == 2'd1)
      chk(progTicks == TIMEOUT, "R4 ticks before abort", progTicks, TIMEOUT);
    if (v.expStatus == 2'd1 || v.expStatus == 2'd2)
      chk(capN == 0, "R3 no bits before handshake", capN, 0);
    chk(progN && cfgClk && cfgData && !busy, "R4 lines high at end",
        {progN, cfgClk, cfgData, busy}, 14);
    if (v.restart)
      chk(badRestart == 0 && restarted, "R13 start ignored while busy", badRestart, 0);
    $display("vector %0d done, status %0d", id, status);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(progN == 1'b1, "R1 progN reset", progN, 1);
    chk(cfgClk == 1'b1 && cfgData == 1'b1, "R1 clk/data reset", {cfgClk, cfgData}, 3);
    chk(busy == 1'b0 && bitReady == 1'b0, "R1 busy/ready reset", {busy, bitReady}, 0);
    chk(status == 2'd0, "R1 status reset", status, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(progN && !busy, "R1 idle after reset", {progN, busy}, 2);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

    // R12: error status is held while idle
    run_vec(VECS[6], 99);
    for (int c = 0; c < 60; c++) begin
      msTick = (c % 4 == 0);
      initIn = c[1];
      doneIn = c[2];
      @(negedge clk);
    end
    msTick = 1'b0; initIn = 1'b1; doneIn = 1'b0;
    chk(status == 2'd3, "R12 status held while idle", status, 3);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk(status == 2'd0 && busy, "R12 status cleared by start", status, 0);
    for (int c = 0; c < 500 && busy; c++) begin
      msTick = ((c % 16) == 15);
      @(negedge clk);
    end
    msTick = 1'b0;
    chk(status == 2'd1 && !busy, "R4 timeout with init stuck high", status, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule